// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Adder

This block adds two signed two's-complement fixed-point numbers whose formats differ. Each operand is described by its total width (sign bit included) and its count of fractional bits, and each has its own pair of parameters. The most significant bit of every operand carries negative weight.

Before the addition, the block lines up the binary points and brings both operands to one common format. It pads the operand with fewer fractional bits with zeros below its LSB. It widens the operand with the shorter integer part by copying its sign bit. It then adds one more copy of the sign bit to both, so the sum is exact and cannot wrap.

The result keeps full precision. Its fractional width is the larger of the two input fractional widths. Its integer width, sign included, is one more than the larger input integer width. The sum is registered, and its valid strobe rises one clock after the input strobe. Rounding, clamping and narrowing of the result are left to whatever logic consumes it.

Top module: `fxadd_top`

## Requirements
- R1: The result has FR = max(A_FRAC, B_FRAC) fractional bits and max(A_W-A_FRAC, B_W-B_FRAC)+1 integer bits, sign included. With the defaults (A is 5 bits with 2 fractional bits, B is 4 bits with 3 fractional bits) the result is 7 bits with 3 fractional bits, so sum_o=1 stands for 2^-3.
- R2: For every input pair, sum_o read as a signed integer equals a_i*2^(FR-A_FRAC) + b_i*2^(FR-B_FRAC), with both inputs read as signed integers.
- R3: The sum never overflows. Adding the most negative values of both operands, or the most positive values of both, gives the exact result.
- R4: out_vld is high in exactly the cycles that follow a clock edge at which in_vld was high.
- R5: When in_vld is low at a clock edge, sum_o keeps its previous value after that edge.
- R6: rst is synchronous and active high. At the first clock edge where it is high, out_vld and sum_o are both cleared to zero.
- R7: The operand with fewer fractional bits is padded with zero bits below its LSB. With the defaults, a_i=5'b10001 added to b_i=0 gives sum_o=7'b1100010.
- R8: The operand with fewer integer bits is widened by replicating its sign bit. With the defaults, b_i=4'b1011 added to a_i=0 gives sum_o=7'b1111011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | High when a_i and b_i hold an operand pair |
| a_i | input | A_W | Operand A, signed, A_FRAC fractional bits |
| b_i | input | B_W | Operand B, signed, B_FRAC fractional bits |
| out_vld | output | 1 | High when sum_o holds a new result |
| sum_o | output | RES_W | Exact signed sum in the common result format |

## Verification
Every result is due exactly one rising edge after its operands are presented. The bench changes its inputs on the falling edge and checks sum_o and out_vld on the next falling edge, which comes after the single register stage has updated. With operands streamed back to back, each check sees only the pair that was driven just before it. The hold and reset checks follow the same rule: they apply a cycle with in_vld low, or with rst high, and observe the outputs on the falling edge that follows that rising edge.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

    function automatic int fx_max(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int res_frac(input int af, input int bf);
        return fx_max(af, bf);
    endfunction

    // integer bits of the result, sign included, with one guard bit
    function automatic int res_int(input int aw, input int af,
                                   input int bw, input int bf);
        return fx_max(aw - af, bw - bf) + 1;
    endfunction

    function automatic int res_width(input int aw, input int af,
                                     input int bw, input int bf);
        return res_int(aw, af, bw, bf) + res_frac(af, bf);
    endfunction

endpackage

// File: rtl/fxadd_align.sv
module fxadd_align #(
    parameter int IN_W  = 5,
    parameter int IN_F  = 2,
    parameter int OUT_W = 7,
    parameter int OUT_F = 3
) (
    input  logic [IN_W-1:0]  x_i,
    output logic [OUT_W-1:0] y_o
);
    localparam int PAD = OUT_F - IN_F;
    localparam int EXT = OUT_W - IN_W - PAD;

    logic [IN_W+PAD-1:0] padded;

    generate
        if (PAD > 0) begin : g_pad
            assign padded = {x_i, {PAD{1'b0}}};
        end else begin : g_nopad
            assign padded = x_i;
        end
    endgenerate

    assign y_o = {{EXT{x_i[IN_W-1]}}, padded};
endmodule

// File: rtl/fxadd_sum.sv
module fxadd_sum #(
    parameter int W = 7
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] s_o
);
    always_comb begin
        s_o = a_i + b_i;
    end
endmodule

// File: rtl/fxadd_outreg.sv
module fxadd_outreg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic         vld_o,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
            q_o   <= '0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) begin
                q_o <= d_i;
            end
        end
    end

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_o);                                    // R4
    AST_VLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> !vld_o);                                  // R4
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vld_i |=> $stable(q_o));                            // R5
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (!vld_o && q_o == '0));                      // R6
endmodule

// File: rtl/fxadd_top.sv
module fxadd_top
    import fxadd_pkg::*;
#(
    parameter int A_W    = 5,
    parameter int A_FRAC = 2,
    parameter int B_W    = 4,
    parameter int B_FRAC = 3
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          in_vld,
    input  logic [A_W-1:0]                                a_i,
    input  logic [B_W-1:0]                                b_i,
    output logic                                          out_vld,
    output logic [res_width(A_W, A_FRAC, B_W, B_FRAC)-1:0] sum_o
);
    localparam int RES_F = res_frac(A_FRAC, B_FRAC);
    localparam int RES_W = res_width(A_W, A_FRAC, B_W, B_FRAC);

    logic [RES_W-1:0] a_al;
    logic [RES_W-1:0] b_al;
    logic [RES_W-1:0] sum_c;

    fxadd_align #(.IN_W(A_W), .IN_F(A_FRAC), .OUT_W(RES_W), .OUT_F(RES_F))
        u_align_a (.x_i(a_i), .y_o(a_al));

    fxadd_align #(.IN_W(B_W), .IN_F(B_FRAC), .OUT_W(RES_W), .OUT_F(RES_F))
        u_align_b (.x_i(b_i), .y_o(b_al));

    fxadd_sum #(.W(RES_W)) u_sum (.a_i(a_al), .b_i(b_al), .s_o(sum_c));

    fxadd_outreg #(.W(RES_W)) u_reg (
        .clk(clk), .rst(rst), .vld_i(in_vld), .d_i(sum_c),
        .vld_o(out_vld), .q_o(sum_o)
    );

    // same-sign operands must give a sum of that sign
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (a_al[RES_W-1] == b_al[RES_W-1]) |-> (sum_c[RES_W-1] == a_al[RES_W-1])); // R3
endmodule

// File: tb/sim_fxadd_top.sv
module sim_fxadd_top;
    localparam int AW = 5, AF = 2, BW = 4, BF = 3;
    localparam int RF = (AF > BF) ? AF : BF;
    localparam int RI = (((AW - AF) > (BW - BF)) ? (AW - AF) : (BW - BF)) + 1;
    localparam int RW = RI + RF;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_vld = 1'b0;
    logic [AW-1:0] a_i = '0;
    logic [BW-1:0] b_i = '0;
    logic out_vld;
    logic [RW-1:0] sum_o;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fxadd_top #(.A_W(AW), .A_FRAC(AF), .B_W(BW), .B_FRAC(BF)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .a_i(a_i), .b_i(b_i),
        .out_vld(out_vld), .sum_o(sum_o)
    );

    function automatic int expect_sum(input logic [AW-1:0] a, input logic [BW-1:0] b);
        int av, bv;
        av = int'($signed(a));
        bv = int'($signed(b));
        return av * (1 << (RF - AF)) + bv * (1 << (RF - BF));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [AW-1:0] a, input logic [BW-1:0] b, input logic v);
        a_i = a; b_i = b; in_vld = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        int held;
        @(negedge clk);
        @(negedge clk);
        // R6 reset state
        chk("R6 vld", int'(out_vld), 0);
        chk("R6 sum", int'($signed(sum_o)), 0);
        rst = 1'b0;

        // R7 zero padding of A
        apply(5'b10001, 4'b0000, 1'b1);
        chk("R7", int'(sum_o), int'(7'b1100010));
        chk("R4 vld", int'(out_vld), 1);
        // R8 sign replication of B
        apply(5'b00000, 4'b1011, 1'b1);
        chk("R8", int'(sum_o), int'(7'b1111011));
        // R1 one LSB of result is 2^-3
        apply(5'b00000, 4'b0001, 1'b1);
        chk("R1 lsb", int'($signed(sum_o)), 1);
        // mixed example
        apply(5'b10001, 4'b1011, 1'b1);
        chk("R2 example", int'(sum_o), int'(7'b1011101));
        // R3 extremes
        apply(5'b10000, 4'b1000, 1'b1);
        chk("R3 min+min", int'($signed(sum_o)), -40);
        apply(5'b01111, 4'b0111, 1'b1);
        chk("R3 max+max", int'($signed(sum_o)), 37);
        chk("R1 width", int'(sum_o[RW-1]), 0);

        // R5 hold with in_vld low, inputs changed
        held = int'($signed(sum_o));
        apply(5'b00011, 4'b0101, 1'b0);
        chk("R4 quiet", int'(out_vld), 0);
        chk("R5 hold", int'($signed(sum_o)), held);
        apply(5'b11100, 4'b1110, 1'b0);
        chk("R5 hold2", int'($signed(sum_o)), held);

        // R2 exhaustive sweep, back to back
        for (int a = 0; a < (1 << AW); a++) begin
            for (int b = 0; b < (1 << BW); b++) begin
                apply(AW'(a), BW'(b), 1'b1);
                chk("R2 sweep", int'($signed(sum_o)), expect_sum(AW'(a), BW'(b)));
                if (b == 0) chk("R4 sweep vld", int'(out_vld), 1);
            end
        end

        // R6 reset mid-run
        rst = 1'b1;
        apply(5'b01111, 4'b0111, 1'b1);
        chk("R6 mid vld", int'(out_vld), 0);
        chk("R6 mid sum", int'($signed(sum_o)), 0);
        rst = 1'b0;
        apply(5'b00001, 4'b0000, 1'b1);
        chk("R4 after rst", int'(out_vld), 1);
        chk("R2 after rst", int'($signed(sum_o)), 2);
        apply(5'b00001, 4'b0000, 1'b0);
        chk("R4 drop", int'(out_vld), 0);

        finish_run();
    end
endmodule